// File: doc/BRIEF.md
# DMA Channel Inactivity Timeout Timer

This block watches a single DMA channel and reports when the channel has been idle too long. A free-running prescaler divides the system clock by 2^8, 2^16 or 2^24, or stops ticking altogether. A tick counter counts the prescaled ticks. Each request strobe or completed transfer sets that counter back to zero. When the counter reaches a power-of-two limit chosen by a 3-bit period code, the block raises a sticky timeout flag.

The timer runs only while the channel is enabled, and disabling the channel returns it to idle. In the normal mode counting starts as soon as the channel is enabled. In the wait mode the timer stays idle until the first transfer on the channel completes. The prescaler is not restarted when counting starts. Because of this, the measured timeout spans a window one prescaled tick wide.

The flag stays set until a clear strobe arrives. It does not set a second time until channel activity, or a disable followed by a new enable, has reset the counter.

Top module: `dma_idle_watchdog`

## Requirements
- R1: Prescale codes 1, 2 and 3 produce one tick every 2^8, 2^16 and 2^24 system clocks. Every tick is a single-cycle pulse.
- R2: Prescale code 0 produces no ticks, so the timeout flag never sets.
- R3: With period code n (3 bits, 0 to 7), the flag rises between (2^(n+2)-1)·P and 2^(n+2)·P+4 clock cycles after the last activity or start of counting, where P is the prescale divide.
- R4: With the wait bit at 1, an enabled channel stays idle and does not count until a transfer-done strobe arrives. Idle means a time-out is impossible.
- R5: With the wait bit at 0, counting starts on the clock after the channel enable goes high.
- R6: Deasserting the channel enable stops the timer and resets its count. A later enable starts a fresh full period.
- R7: A request strobe or a transfer-done strobe on an armed channel resets the tick count to zero.
- R8: Once set, the timeout flag stays at 1 until a clear strobe, and it reads 0 on the clock after the clear strobe.
- R9: After a timeout, the flag does not set again until activity or re-enabling has reset the count.
- R10: After reset, the timeout flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable; low holds the timer idle |
| xfer_done | input | 1 | One-cycle strobe: a transfer completed |
| req_pulse | input | 1 | One-cycle strobe: a request was serviced |
| flag_clr | input | 1 | One-cycle strobe clearing the timeout flag |
| pre_sel | input | 2 | Prescale code: 0 off, 1/2/3 divide by 2^8/2^16/2^24 |
| per_sel | input | 3 | Period code n, limit of 2^(n+2) ticks |
| wait_first | input | 1 | 1: hold the timer until the first completed transfer |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
On every cycle the assertions check the following:
- ticks are isolated single pulses and are absent with the prescaler off;
- a disabled channel is disarmed and holds a zero count;
- the wait mode holds the timer until a completed transfer;
- activity zeroes the count;
- a raised flag holds until cleared and never re-fires from a spent count.

Only the bench scenarios can show the following:
- the real timeout distance lands inside the one-tick window for different period codes;
- periodic requests and transfers keep a channel alive indefinitely;
- a disable in mid-count restarts a full period.

// File: rtl/dma_wdt_pkg.sv
package dma_wdt_pkg;
  localparam int PRE_STEP  = 8;  // log2 of divide per prescale code step
  localparam int PRE_STEPS = 3;  // number of non-zero prescale codes
  localparam int PER_W     = 3;  // period code width
  localparam int BASE_EXP  = 2;  // code 0 means 2^BASE_EXP ticks

  function automatic int cnt_width(input int per_w, input int base_exp);
    return (1 << per_w) - 1 + base_exp + 1;
  endfunction
endpackage

// File: rtl/dma_wdt_prescaler.sv
module dma_wdt_prescaler #(
  parameter int STEP   = 8,
  parameter int STAGES = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = STEP * STAGES;

  logic [PRE_W-1:0]  pc;
  logic [STAGES:0]   carry;
  logic              pick;

  assign carry[0] = 1'b0;  // code 0: timer clock off

  genvar k;
  generate
    for (k = 1; k <= STAGES; k++) begin : g_stage
      assign carry[k] = &pc[k*STEP-1:0];
    end
  endgenerate

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i <= STAGES; i++) begin
      if (sel == SEL_W'(i)) pick = carry[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      tick <= 1'b0;
    end else begin
      pc   <= pc + 1'b1;
      tick <= pick;
    end
  end

  // R2: prescaler off gives no tick
  p_off_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |=> !tick);
  // R1: ticks are isolated single-cycle pulses
  p_tick_isolated_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dma_wdt_arm.sv
module dma_wdt_arm (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wait_first,
  input  logic done,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst)              armed <= 1'b0;
    else if (!en)         armed <= 1'b0;
    else if (!wait_first || done) armed <= 1'b1;
  end

  // R6: disable disarms
  p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !armed);
  // R5: immediate start without wait mode
  p_immediate_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !wait_first) |=> armed);
  // R4: wait mode holds until a completed transfer
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (en && wait_first && !armed && !done) |=> !armed);
endmodule

// File: rtl/dma_wdt_counter.sv
module dma_wdt_counter #(
  parameter int PER_W    = 3,
  parameter int BASE_EXP = 2,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             tick,
  input  logic             act,
  input  logic             clr,
  input  logic [PER_W-1:0] per_sel,
  output logic             flag
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             fired;
  logic             fire_evt;

  assign lim      = CNT_W'(1) << (int'(per_sel) + BASE_EXP);
  assign fire_evt = armed && !act && !fired && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!armed || act) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (fire_evt) fired <= 1'b1;
      if (tick && !fired && cnt < lim) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (fire_evt) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R7: activity zeroes the count
  p_act_clears_r7: assert property (@(posedge clk) disable iff (rst)
    act |=> (cnt == '0));
  // R6: disarmed channel holds a zero count
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (cnt == '0));
  // R8: flag holds until cleared
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R9: a spent count does not re-fire
  p_no_refire_r9: assert property (@(posedge clk) disable iff (rst)
    (fired && !flag && armed && !act) |=> !flag);
endmodule

// File: rtl/dma_idle_watchdog.sv
module dma_idle_watchdog
  import dma_wdt_pkg::*;
#(
  parameter int STEP     = PRE_STEP,
  parameter int STAGES   = PRE_STEPS,
  parameter int PSEL_W   = 2,
  parameter int PERSEL_W = PER_W,
  parameter int EXP0     = BASE_EXP
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ch_en,
  input  logic                xfer_done,
  input  logic                req_pulse,
  input  logic                flag_clr,
  input  logic [PSEL_W-1:0]   pre_sel,
  input  logic [PERSEL_W-1:0] per_sel,
  input  logic                wait_first,
  output logic                timeout_flag
);
  localparam int CW = cnt_width(PERSEL_W, EXP0);

  logic tick;
  logic armed;
  logic act;

  assign act = req_pulse || xfer_done;

  dma_wdt_prescaler #(.STEP(STEP), .STAGES(STAGES), .SEL_W(PSEL_W)) i_pre (
    .clk(clk), .rst(rst), .sel(pre_sel), .tick(tick));

  dma_wdt_arm i_arm (
    .clk(clk), .rst(rst), .en(ch_en), .wait_first(wait_first),
    .done(xfer_done), .armed(armed));

  dma_wdt_counter #(.PER_W(PERSEL_W), .BASE_EXP(EXP0), .CNT_W(CW)) i_cnt (
    .clk(clk), .rst(rst), .armed(armed), .tick(tick), .act(act),
    .clr(flag_clr), .per_sel(per_sel), .flag(timeout_flag));

  // R10: flag low right after reset
  p_reset_low_r10: assert property (@(posedge clk) rst |=> !timeout_flag);
endmodule

// File: tb/test_dma_idle_watchdog.sv
module test_dma_idle_watchdog;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ch_en = 0, xfer_done = 0, req_pulse = 0, flag_clr = 0, wait_first = 0;
  logic [1:0] pre_sel = 0;
  logic [2:0] per_sel = 0;
  logic timeout_flag;

  always #4 clk = ~clk;  // 125 MHz

  dma_idle_watchdog i_dma_idle_watchdog (
    .clk(clk), .rst(rst), .ch_en(ch_en), .xfer_done(xfer_done),
    .req_pulse(req_pulse), .flag_clr(flag_clr), .pre_sel(pre_sel),
    .per_sel(per_sel), .wait_first(wait_first), .timeout_flag(timeout_flag));

  typedef struct { string tag; int lo; int hi; } exp_t;
  exp_t exp_q[$];

  int nchk = 0, nfail = 0;
  int cyc = 0, mark_t = 0;
  logic prev_flag = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: pop expected timeout windows when the flag rises
  always @(negedge clk) begin
    if (!rst && timeout_flag && !prev_flag) begin
      int el;
      el = cyc - mark_t;
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R9: actual unexpected timeout at %0d cycles expected none", el);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (el < e.lo || el > e.hi) begin
          nfail++;
          $display("FAIL %s: actual %0d cycles expected %0d..%0d", e.tag, el, e.lo, e.hi);
        end
      end
    end
    prev_flag <= timeout_flag;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_window(input string tag, input int code);
    exp_t e;
    int lim;
    lim = 1 << (code + 2);
    e.tag = tag; e.lo = (lim - 1) * 256; e.hi = lim * 256 + 4;
    exp_q.push_back(e);
  endtask

  task automatic pulse_req();
    req_pulse = 1; mark_t = cyc; @(negedge clk); req_pulse = 0;
  endtask

  task automatic pulse_done();
    xfer_done = 1; mark_t = cyc; @(negedge clk); xfer_done = 0;
  endtask

  task automatic wait_flag(input string tag);
    int n = 0;
    while (!timeout_flag && n < 6000) begin @(negedge clk); n++; end
    check({tag, " flag raised"}, int'(timeout_flag), 1);
    idle(2);
  endtask

  task automatic do_clear();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    @(negedge clk);
    check("R8 flag cleared", int'(timeout_flag), 0);
  endtask

  task automatic finish_run();
    check("queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 0;
    @(negedge clk);
    check("R10 flag after reset", int'(timeout_flag), 0);

    // R5 + R3 code 0: immediate start at enable
    pre_sel = 1; per_sel = 0; wait_first = 0;
    expect_window("R5 R3 code0", 0);
    ch_en = 1; mark_t = cyc;
    wait_flag("R5");
    idle(50);
    check("R8 flag sticky", int'(timeout_flag), 1);
    do_clear();
    idle(3000);
    check("R9 no refire", int'(timeout_flag), 0);

    // R3 code 1
    per_sel = 1;
    expect_window("R3 code1", 1);
    pulse_req();
    wait_flag("R3");
    do_clear();

    // R7: activity keeps the channel alive
    per_sel = 0;
    for (int i = 0; i < 6; i++) begin
      if (i % 2 == 0) pulse_req(); else pulse_done();
      idle(500);
    end
    check("R7 alive", int'(timeout_flag), 0);
    expect_window("R7 after last activity", 0);
    pulse_req();
    wait_flag("R7");
    do_clear();

    // R6: disable mid-count restarts a full period
    pulse_req();
    idle(600);
    ch_en = 0; idle(10);
    check("R6 no flag while off", int'(timeout_flag), 0);
    expect_window("R6 fresh period", 0);
    ch_en = 1; mark_t = cyc;
    wait_flag("R6");
    do_clear();

    // R4: wait mode holds until first completed transfer
    ch_en = 0; idle(2);
    wait_first = 1; ch_en = 1;
    pulse_req();
    idle(3000);
    check("R4 idle before done", int'(timeout_flag), 0);
    expect_window("R4 after first done", 0);
    pulse_done();
    wait_flag("R4");
    do_clear();

    // R2: prescaler off never times out
    wait_first = 0; pre_sel = 0;
    pulse_req();
    idle(3000);
    check("R2 no timeout when off", int'(timeout_flag), 0);

    // R1: code 2 divides by 2^16, so no timeout within 3000 cycles
    pre_sel = 2;
    pulse_req();
    idle(3000);
    check("R1 slow prescale", int'(timeout_flag), 0);

    done_flag = 1;
    finish_run();
  end
endmodule